// File: doc/BRIEF.md
# Multi-site temperature monitor register block

This block is the control and result interface of an on-chip temperature monitor with up to sixteen sensing sites. Software reaches it over a simple 32-bit register bus with word-aligned byte addresses. It sets an enable bit and picks the sites to watch. The block then scans those sites on a fixed schedule. On each visit it latches the site's raw sensor reading and an in-range flag from the sensor port into that site's read-only result register.

A `VERSION` parameter picks one of two result conventions. Version 1 selects sites through a reversed bitmap inside the mode register and reports whole degrees Celsius in eight bits. Version 2 selects sites through a separate natural-order site register and reports whole kelvins in nine bits, with a half-degree flag above them. Both versions also hold an interrupt-enable register, two configuration registers and a bank of range-control registers. No logic inside the block uses these registers; they only keep what software writes to them. A read-only revision register reports which version was built.

Top module: `tmon_regs`

## Requirements
- R1: After reset, the mode register, the site register, the interrupt-enable register, both configuration registers, every range register and every result register read zero, and the interval register reads 0xF.
- R2: A read request returns its data one cycle later with `rvalid_o` high. Any offset that does not name a register, including any offset that is not word-aligned, reads zero.
- R3: Bit 31 of the mode register (offset 0x000) enables monitoring. Writing 0 to that register disables it, and every result's valid flag is then low from the next cycle on.
- R4: In version 1, site n is selected by mode-register bit (15 − n). In version 2, site n is selected by bit n of the site register at 0x008, and bits 15:0 of the mode register select nothing.
- R5: While monitoring is enabled, the scanner visits sites 0 to N−1 in ascending order, one site per cycle. It then idles for (interval + 1) × `PRESCALE` cycles and starts the next pass. Each visit to a selected site latches that site's current sensor value.
- R6: The result for site n is at 0x100 + 16·n. In version 1, bits 7:0 hold the low byte of the raw value, and bits 30:8 read zero.
- R7: In version 2, bits 8:0 hold the raw kelvin value, bit 9 holds the half-degree flag (raw bit 9), and bits 30:10 read zero.
- R8: Bit 31 of a result takes the sensor's in-range flag at the moment of capture. An out-of-range capture still updates the temperature field, but leaves valid low.
- R9: Bus writes to result offsets have no effect.
- R10: The interval register is at 0x008 in version 1 and at 0x00C in version 2. It stores the low `IVL_W` bits of a write.
- R11: The interrupt-enable register (0x020), the temperature configuration register (0x080), the sensor configuration register (0x084) and the range registers (0xF10 + 4·k) each read back all 32 bits of the last write.
- R12: The register at 0xBF8 reads the version number in bits 15:8, with every other bit zero. Writes to it have no effect.
- R13: Deselecting one site while monitoring stays on clears only that site's valid flag, from the next cycle on. Its temperature field keeps its value, and the other sites are not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rvalid_o | output | 1 | Read data valid, one cycle after a read request |
| rdata_o | output | 32 | Read data |
| sens_raw_i | input | NUM_SITES*10 | Raw sensor reading per site, site n in bits 10n+9:10n |
| sens_ok_i | input | NUM_SITES | Per-site in-range flag from the sensor |

## Verification
The assertions check on every cycle that reads answer one cycle after they are requested. They also check that the revision value never changes, that the scanner index steps upward and always pauses after the last site, that a deselected or disabled site loses its valid flag on the next cycle, and that a capture copies the in-range flag. The bench scenarios cover what only a complete exchange can show: each version's site bitmap convention, the bit packing of both result formats, writes that leave read-only registers untouched, and a rescan that picks up a changed sensor value.

// File: rtl/tmon_pkg.sv
package tmon_pkg;
  localparam int ADDR_W = 12;
  localparam int RAW_W  = 10;

  localparam logic [ADDR_W-1:0] OFS_MODE    = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_SITE_V2 = 12'h008;
  localparam logic [ADDR_W-1:0] OFS_IVL_V1  = 12'h008;
  localparam logic [ADDR_W-1:0] OFS_IVL_V2  = 12'h00C;
  localparam logic [ADDR_W-1:0] OFS_IRQ     = 12'h020;
  localparam logic [ADDR_W-1:0] OFS_TCFG    = 12'h080;
  localparam logic [ADDR_W-1:0] OFS_SCFG    = 12'h084;
  localparam logic [ADDR_W-1:0] OFS_REV     = 12'hBF8;
  localparam int RES_BASE   = 'h100;
  localparam int RES_STRIDE = 16;
  localparam int RNG_BASE   = 'hF10;

  typedef enum logic {PH_SCAN, PH_WAIT} scan_ph_e;
endpackage

// File: rtl/tmon_scan.sv
module tmon_scan
  import tmon_pkg::*;
#(
  parameter int NUM_SITES = 16,
  parameter int IVL_W     = 8,
  parameter int PRESCALE  = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  en_i,
  input  logic [IVL_W-1:0]      ivl_i,
  output logic                  visit_o,
  output logic [$clog2(NUM_SITES)-1:0] idx_o
);
  localparam int SIDX_W = $clog2(NUM_SITES);
  localparam int CNT_W  = $clog2((1 << IVL_W) * PRESCALE + 1);
  localparam logic [SIDX_W-1:0] LAST = SIDX_W'(NUM_SITES - 1);

  scan_ph_e           ph_q;
  logic [SIDX_W-1:0]  idx_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [CNT_W-1:0]   wait_load;

  assign wait_load = CNT_W'((32'(ivl_i) + 32'd1) * 32'(PRESCALE) - 32'd1);
  assign visit_o   = en_i && (ph_q == PH_SCAN);
  assign idx_o     = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_SCAN;
      idx_q <= '0;
      cnt_q <= '0;
    end else if (!en_i) begin
      ph_q  <= PH_SCAN;
      idx_q <= '0;
      cnt_q <= '0;
    end else begin
      case (ph_q)
        PH_SCAN: begin
          if (idx_q == LAST) begin
            idx_q <= '0;
            ph_q  <= PH_WAIT;
            cnt_q <= wait_load;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        default: begin
          if (cnt_q == '0) ph_q <= PH_SCAN;
          else             cnt_q <= cnt_q - 1'b1;
        end
      endcase
    end
  end

  // R5
  idx_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    visit_o && (idx_o != LAST) |=> !en_i || (visit_o && (idx_o == $past(idx_o) + 1'b1)));
  // R5
  pass_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    visit_o && (idx_o == LAST) |=> !visit_o);
endmodule

// File: rtl/tmon_site.sv
module tmon_site
  import tmon_pkg::*;
#(
  parameter int VERSION = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             cap_i,
  input  logic [RAW_W-1:0] raw_i,
  input  logic             ok_i,
  output logic [31:0]      res_o
);
  logic             valid_q;
  logic [RAW_W-1:0] temp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      temp_q  <= '0;
    end else if (clr_i) begin
      valid_q <= 1'b0;
    end else if (cap_i) begin
      valid_q <= ok_i;
      temp_q  <= raw_i;
    end
  end

  // v1: whole degrees C in 7:0; v2: kelvin in 8:0, half-degree in 9
  assign res_o = (VERSION == 1) ? {valid_q, 23'b0, temp_q[7:0]}
                                : {valid_q, 21'b0, temp_q};

  // R3 R13
  clr_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !res_o[31]);
  // R8
  cap_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i && !clr_i |=> res_o[31] == $past(ok_i));
endmodule

// File: rtl/tmon_regs.sv
module tmon_regs
  import tmon_pkg::*;
#(
  parameter int NUM_SITES = 16,
  parameter int VERSION   = 1,
  parameter int PRESCALE  = 4,
  parameter int IVL_W     = 8,
  parameter int NUM_RANGE = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       req_i,
  input  logic                       we_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [31:0]                wdata_i,
  output logic                       rvalid_o,
  output logic [31:0]                rdata_o,
  input  logic [NUM_SITES*RAW_W-1:0] sens_raw_i,
  input  logic [NUM_SITES-1:0]       sens_ok_i
);
  localparam int SIDX_W = $clog2(NUM_SITES);
  localparam logic [ADDR_W-1:0] IVL_OFS = (VERSION == 1) ? OFS_IVL_V1 : OFS_IVL_V2;
  localparam logic [31:0] REV_VAL = {16'b0, 8'(VERSION), 8'b0};

  logic [31:0]      mode_q, irq_q, tcfg_q, scfg_q;
  logic [15:0]      site_q;
  logic [IVL_W-1:0] ivl_q;
  logic [31:0]      range_q [NUM_RANGE];
  logic [31:0]      res     [NUM_SITES];
  logic [NUM_SITES-1:0] site_en;
  logic             mon_en, visit, wr_en, rd_en, rvalid_q;
  logic [SIDX_W-1:0] scan_idx;
  logic [31:0]      rd_d, rdata_q;

  assign wr_en  = req_i && we_i;
  assign rd_en  = req_i && !we_i;
  assign mon_en = mode_q[31];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      site_q <= '0;
      ivl_q  <= IVL_W'(15);
      irq_q  <= '0;
      tcfg_q <= '0;
      scfg_q <= '0;
      for (int k = 0; k < NUM_RANGE; k++) range_q[k] <= '0;
    end else if (wr_en) begin
      if (addr_i == OFS_MODE) mode_q <= wdata_i;
      if (VERSION == 2 && addr_i == OFS_SITE_V2) site_q <= wdata_i[15:0];
      if (addr_i == IVL_OFS)  ivl_q  <= wdata_i[IVL_W-1:0];
      if (addr_i == OFS_IRQ)  irq_q  <= wdata_i;
      if (addr_i == OFS_TCFG) tcfg_q <= wdata_i;
      if (addr_i == OFS_SCFG) scfg_q <= wdata_i;
      for (int k = 0; k < NUM_RANGE; k++)
        if (addr_i == ADDR_W'(RNG_BASE + 4 * k)) range_q[k] <= wdata_i;
    end
  end

  // site bitmap convention differs per version
  for (genvar n = 0; n < NUM_SITES; n++) begin : g_sel
    if (VERSION == 1) begin : g_v1
      assign site_en[n] = mode_q[15-n];
    end else begin : g_v2
      assign site_en[n] = site_q[n];
    end
  end

  tmon_scan #(
    .NUM_SITES(NUM_SITES),
    .IVL_W    (IVL_W),
    .PRESCALE (PRESCALE)
  ) u_scan (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (mon_en),
    .ivl_i  (ivl_q),
    .visit_o(visit),
    .idx_o  (scan_idx)
  );

  for (genvar n = 0; n < NUM_SITES; n++) begin : g_site
    tmon_site #(.VERSION(VERSION)) u_site (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .clr_i (!mon_en || !site_en[n]),
      .cap_i (visit && (scan_idx == SIDX_W'(n)) && site_en[n]),
      .raw_i (sens_raw_i[n*RAW_W +: RAW_W]),
      .ok_i  (sens_ok_i[n]),
      .res_o (res[n])
    );
  end

  always_comb begin
    rd_d = '0;
    if (addr_i == OFS_MODE) rd_d = mode_q;
    if (addr_i == IVL_OFS)  rd_d = {{(32-IVL_W){1'b0}}, ivl_q};
    if (VERSION == 2 && addr_i == OFS_SITE_V2) rd_d = {16'b0, site_q};
    if (addr_i == OFS_IRQ)  rd_d = irq_q;
    if (addr_i == OFS_TCFG) rd_d = tcfg_q;
    if (addr_i == OFS_SCFG) rd_d = scfg_q;
    if (addr_i == OFS_REV)  rd_d = REV_VAL;
    for (int n = 0; n < NUM_SITES; n++)
      if (addr_i == ADDR_W'(RES_BASE + RES_STRIDE * n)) rd_d = res[n];
    for (int k = 0; k < NUM_RANGE; k++)
      if (addr_i == ADDR_W'(RNG_BASE + 4 * k)) rd_d = range_q[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= rd_en;
      rdata_q  <= rd_en ? rd_d : '0;
    end
  end

  assign rvalid_o = rvalid_q;
  assign rdata_o  = rdata_q;

  // R2
  rd_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en |=> rvalid_o);
  // R2
  rd_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> $past(rd_en));
  // R12
  rev_fixed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o && ($past(addr_i) == OFS_REV) |-> rdata_o == REV_VAL);
endmodule

// File: tb/tmon_regs_tb.sv
module tmon_regs_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        req = 1'b0, we = 1'b0, sel = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [NS*10-1:0] raw_v = '0;
  logic [NS-1:0]    ok_v  = '0;
  logic        req1, req2, rv1, rv2;
  logic [31:0] rd1, rd2;

  assign req1 = req && !sel;
  assign req2 = req && sel;

  tmon_regs #(.NUM_SITES(NS), .VERSION(1)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req1), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rvalid_o(rv1), .rdata_o(rd1),
    .sens_raw_i(raw_v), .sens_ok_i(ok_v));

  tmon_regs #(.NUM_SITES(NS), .VERSION(2)) dut_v2_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req2), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rvalid_o(rv2), .rdata_o(rd2),
    .sens_raw_i(raw_v), .sens_ok_i(ok_v));

  int total = 0;
  int bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  task automatic rd(input logic s, input logic [11:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    sel = s; req = 1'b1; we = 1'b0; addr = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    req = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr(input logic s, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    sel = s; req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic set_raw(input int n, input logic [9:0] v, input logic ok);
    raw_v[n*10 +: 10] = v;
    ok_v[n] = ok;
  endtask

  task automatic settle(input int cyc);
    repeat (cyc) @(negedge clk);
  endtask

  // monitor: pop expected item when the selected device returns data
  always @(negedge clk) begin
    if (sel ? rv2 : rv1) begin
      logic [31:0] act;
      act = sel ? rd2 : rd1;
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R2 unexpected read data actual=%h expected=none", act);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (act !== e) begin
          bad++;
          $display("FAIL %s actual=%h expected=%h", t, act, e);
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R2 watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int n = 0; n < NS; n++) set_raw(n, 10'(20 + n), 1'b1);
    set_raw(5, 10'd25, 1'b0);
    set_raw(2, 10'h116, 1'b1);
    settle(3);
    rst_n = 1'b1;
    settle(2);

    // R1 reset state
    rd(0, 12'h000, 32'h0, "R1 v1 mode reset");
    rd(0, 12'h008, 32'hF, "R1 R10 v1 interval reset");
    rd(0, 12'h100, 32'h0, "R1 v1 result reset");
    rd(0, 12'hF10, 32'h0, "R1 range reset");
    rd(1, 12'h00C, 32'hF, "R1 R10 v2 interval reset");
    rd(1, 12'h008, 32'h0, "R1 v2 site reg reset");
    // R12 revision
    rd(0, 12'hBF8, 32'h0000_0100, "R12 v1 revision");
    rd(1, 12'hBF8, 32'h0000_0200, "R12 v2 revision");
    wr(0, 12'hBF8, 32'hFFFF_FFFF);
    rd(0, 12'hBF8, 32'h0000_0100, "R12 revision write ignored");
    // R2 unmapped / misaligned
    rd(0, 12'h004, 32'h0, "R2 unmapped 0x004");
    rd(0, 12'h200, 32'h0, "R2 unmapped 0x200");
    wr(0, 12'h020, 32'hA5A5_0001);
    rd(0, 12'h022, 32'h0, "R2 misaligned");
    // R11 configuration readback
    rd(0, 12'h020, 32'hA5A5_0001, "R11 irq enable");
    wr(0, 12'h080, 32'h1234_5678);
    wr(0, 12'h084, 32'h8765_4321);
    wr(0, 12'hF1C, 32'hDEAD_BEEF);
    wr(0, 12'hF4C, 32'h0BAD_F00D);
    rd(0, 12'h080, 32'h1234_5678, "R11 temp cfg");
    rd(0, 12'h084, 32'h8765_4321, "R11 sensor cfg");
    rd(0, 12'hF1C, 32'hDEAD_BEEF, "R11 range 3");
    rd(0, 12'hF4C, 32'h0BAD_F00D, "R11 range 15");
    // R10 interval width
    wr(0, 12'h008, 32'hFFFF_FF03);
    rd(0, 12'h008, 32'h0000_0003, "R10 v1 interval low bits");

    // v1: sites 0,2,5 via reversed bits 15,13,10
    wr(0, 12'h000, 32'h8000_0000 | 32'h8000 | 32'h2000 | 32'h0400);
    settle(100);
    rd(0, 12'h100, 32'h8000_0014, "R4 R6 v1 site0");
    rd(0, 12'h120, 32'h8000_0016, "R6 v1 site2 high raw bits dropped");
    rd(0, 12'h150, 32'h0000_0019, "R8 out of range site5");
    rd(0, 12'h110, 32'h0, "R4 v1 unselected site1");
    // R9
    wr(0, 12'h100, 32'hFFFF_FFFF);
    rd(0, 12'h100, 32'h8000_0014, "R9 result write ignored");
    // R5 rescan picks up new value
    set_raw(0, 10'h033, 1'b1);
    settle(100);
    rd(0, 12'h100, 32'h8000_0033, "R5 rescan site0");
    // R13 deselect site0 only
    wr(0, 12'h000, 32'h8000_0000 | 32'h2000 | 32'h0400);
    rd(0, 12'h100, 32'h0000_0033, "R13 deselected site keeps data");
    rd(0, 12'h120, 32'h8000_0016, "R13 other site untouched");
    // R3 disable
    wr(0, 12'h000, 32'h0);
    rd(0, 12'h120, 32'h0000_0016, "R3 disable clears valid");
    rd(0, 12'h000, 32'h0, "R3 mode reads zero");

    // v2: sites 0 and 3 via site register
    set_raw(3, 10'h32C, 1'b1);
    wr(1, 12'h008, 32'h0000_0009);
    wr(1, 12'h00C, 32'h0000_0002);
    rd(1, 12'h008, 32'h0000_0009, "R4 v2 site reg readback");
    rd(1, 12'h00C, 32'h0000_0002, "R10 v2 interval");
    wr(1, 12'h000, 32'h8000_0000);
    settle(100);
    rd(1, 12'h130, 32'h8000_032C, "R7 v2 kelvin with half degree");
    rd(1, 12'h100, 32'h8000_0033, "R7 v2 site0");
    rd(1, 12'h110, 32'h0, "R4 v2 unselected site1");
    // R4 v2 ignores mode bitmap
    wr(1, 12'h008, 32'h0);
    wr(1, 12'h000, 32'h8000_8000);
    settle(100);
    rd(1, 12'h100, 32'h0000_0033, "R4 v2 mode bit15 selects nothing");

    settle(4);
    if (exp_q.size() != 0) begin
      total++;
      bad++;
      $display("FAIL R2 missing reads actual=%0d expected=0", exp_q.size());
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule